// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two binary floating-point operands, called A and B, under one of seven selectable conditions. It returns a single result bit one clock after the request. The default format is single precision: one sign bit, 8 exponent bits and 23 fraction bits. The exponent and fraction widths are parameters, so the same logic also serves narrower formats.

Each condition has a fixed operand order. Each condition also has a fixed behaviour when an operand is not a number (NaN). The *signaling* conditions treat any NaN as an invalid operation. The *quiet* conditions do so only for signaling NaNs.

An invalid operation sets a sticky flag, which stays set until software pulses a clear strobe. An invalid operation also raises a one-cycle exception request when two enables are both high: a configuration enable for floating-point exceptions and the global exception enable.

Top module: `fcmp_unit`

## Requirements
- R1: Condition code 0 (unordered) returns 1 when either operand is a NaN, quiet or signaling, and 0 otherwise.
- R2: Unordered marks the operation invalid only when at least one operand is a signaling NaN; a quiet NaN alone leaves the invalid flag unchanged.
- R3: Code 1 returns B < A, code 3 returns A <= B and code 4 returns A < B. All three are signaling: any NaN operand gives result 0 and marks the operation invalid.
- R4: Code 2 is a quiet equality test: a NaN operand gives 0 and marks invalid only for a signaling NaN. Code 5 is its exact negation, returning 1 for any NaN, with the same invalid rule.
- R5: Code 6 returns the negation of the signaling A < B test. It therefore returns 1 when an operand is a NaN, and any NaN marks the operation invalid.
- R6: Ordered values compare by numeric value, with negative values below positive ones, and +0 and -0 compare equal.
- R7: A NaN has an all-ones exponent and a nonzero fraction. It is signaling when the most significant fraction bit is 0. An all-ones exponent with a zero fraction is an infinity and compares as an ordered value.
- R8: Code 7 is reserved: result 0, never invalid.
- R9: res_valid and res_bit appear on the clock edge after the edge that samples cmp_valid high. When cmp_valid was low, res_valid and res_bit are 0 and the invalid flag is not set.
- R10: inv_sticky is set by an invalid comparison and holds until inv_clr is sampled high. A clear and a set in the same cycle leave the flag set.
- R11: exc_req pulses for one cycle, together with res_valid, exactly when that comparison was invalid and both cfg_fpexc_en and glb_exc_en were high when the request was sampled.
- R12: During and after reset, res_valid, res_bit, inv_sticky and exc_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Comparison request |
| cmp_cond | input | 3 | Condition code: 0 unordered, 1 B<A, 2 equal, 3 A<=B, 4 A<B, 5 not equal, 6 not(A<B), 7 reserved |
| opnd_a | input | 1+EXP_W+MAN_W | Operand A |
| opnd_b | input | 1+EXP_W+MAN_W | Operand B |
| cfg_fpexc_en | input | 1 | Configuration enable for floating-point exceptions |
| glb_exc_en | input | 1 | Global exception enable |
| inv_clr | input | 1 | Clear strobe for the sticky invalid flag |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_bit | output | 1 | Comparison result |
| inv_sticky | output | 1 | Sticky invalid-operation flag |
| exc_req | output | 1 | One-cycle exception request |

## Verification
Each fault shows at the ports one cycle after the faulty request, because the result, the flag and the exception request are each registered once:

- A misclassified NaN or a wrong signaling/quiet split appears on the next cycle as a wrong res_bit or a missing or spurious inv_sticky.
- A wrong operand order or a wrong sign handling flips res_bit for about half of the ordered pairs under that condition.
- A flag that fails to hold is seen at the first request after the set that neither raises invalid nor clears.

The bench sweeps a reduced 6-bit format exhaustively. It applies every condition code to every operand pair, with the enables and the clear strobe varying, and compares each cycle against an integer ordering model.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef enum logic [2:0] {
      CC_UNORD = 3'd0,
      CC_BLTA  = 3'd1,
      CC_EQ    = 3'd2,
      CC_ALEB  = 3'd3,
      CC_ALTB  = 3'd4,
      CC_NE    = 3'd5,
      CC_NLT   = 3'd6,
      CC_RSVD  = 3'd7
   } cmp_cond_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic nan;
      logic snan;
   } opclass_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   output fcmp_pkg::opclass_t   cls
);
   localparam int W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] frac_f;
   logic             exp_max;
   logic             frac_nz;

   assign exp_f   = op[W-2:MAN_W];
   assign frac_f  = op[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign frac_nz = |frac_f;

   always_comb begin
      cls.sign = op[W-1];
      cls.zero = ~|op[W-2:0];
      cls.nan  = exp_max & frac_nz;
      cls.snan = exp_max & frac_nz & ~frac_f[MAN_W-1];
   end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   output logic                 a_lt_b,
   output logic                 b_lt_a,
   output logic                 a_eq_b
);
   localparam int W = 1 + EXP_W + MAN_W;

   function automatic logic lt_fn(input logic [W-1:0] x, input logic [W-1:0] y);
      logic both_zero;
      both_zero = ~|x[W-2:0] & ~|y[W-2:0];
      if (both_zero)
         return 1'b0;
      else if (x[W-1] != y[W-1])
         return x[W-1];
      else if (!x[W-1])
         return x[W-2:0] < y[W-2:0];
      else
         return x[W-2:0] > y[W-2:0];
   endfunction

   assign a_lt_b = lt_fn(a, b);
   assign b_lt_a = lt_fn(b, a);
   assign a_eq_b = (a == b) | (~|a[W-2:0] & ~|b[W-2:0]);
endmodule

// File: rtl/fcmp_select.sv
module fcmp_select (
   input  fcmp_pkg::cmp_cond_e cond,
   input  fcmp_pkg::opclass_t  cls_a,
   input  fcmp_pkg::opclass_t  cls_b,
   input  logic                a_lt_b,
   input  logic                b_lt_a,
   input  logic                a_eq_b,
   output logic                raw_res,
   output logic                raw_inv
);
   import fcmp_pkg::*;

   logic any_nan;
   logic any_snan;

   assign any_nan  = cls_a.nan | cls_b.nan;
   assign any_snan = cls_a.snan | cls_b.snan;

   always_comb begin
      raw_res = 1'b0;
      raw_inv = 1'b0;
      unique case (cond)
         CC_UNORD: begin raw_res = any_nan;                       raw_inv = any_snan; end
         CC_BLTA:  begin raw_res = ~any_nan & b_lt_a;             raw_inv = any_nan;  end
         CC_EQ:    begin raw_res = ~any_nan & a_eq_b;             raw_inv = any_snan; end
         CC_ALEB:  begin raw_res = ~any_nan & (a_lt_b | a_eq_b);  raw_inv = any_nan;  end
         CC_ALTB:  begin raw_res = ~any_nan & a_lt_b;             raw_inv = any_nan;  end
         CC_NE:    begin raw_res = any_nan | ~a_eq_b;             raw_inv = any_snan; end
         CC_NLT:   begin raw_res = any_nan | ~a_lt_b;             raw_inv = any_nan;  end
         default:  begin raw_res = 1'b0;                          raw_inv = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/fcmp_flag.sv
module fcmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic raw_inv,
   input  logic clr,
   input  logic cfg_en,
   input  logic glb_en,
   output logic sticky,
   output logic exc_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky    <= 1'b0;
         exc_pulse <= 1'b0;
      end else begin
         sticky    <= (sticky & ~clr) | (req & raw_inv);
         exc_pulse <= req & raw_inv & cfg_en & glb_en;
      end
   end

   p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sticky && !clr |=> sticky);
   p_no_spurious_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky && !(req && raw_inv) |=> !sticky);
   p_exc_has_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> sticky);
   p_exc_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && glb_en) |=> !exc_pulse);
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmp_valid,
   input  logic [2:0]           cmp_cond,
   input  logic [EXP_W+MAN_W:0] opnd_a,
   input  logic [EXP_W+MAN_W:0] opnd_b,
   input  logic                 cfg_fpexc_en,
   input  logic                 glb_exc_en,
   input  logic                 inv_clr,
   output logic                 res_valid,
   output logic                 res_bit,
   output logic                 inv_sticky,
   output logic                 exc_req
);
   import fcmp_pkg::*;

   localparam int W     = 1 + EXP_W + MAN_W;
   localparam int N_OPS = 2;

   initial begin
      assert (EXP_W >= 2) else $error("fcmp_unit: EXP_W must be at least 2");
      assert (MAN_W >= 2) else $error("fcmp_unit: MAN_W must be at least 2");
   end

   cmp_cond_e        cond_e;
   logic [W-1:0]     ops [N_OPS];
   opclass_t         cls [N_OPS];
   logic             a_lt_b, b_lt_a, a_eq_b;
   logic             raw_res, raw_inv;

   assign cond_e = cmp_cond_e'(cmp_cond);
   assign ops[0] = opnd_a;
   assign ops[1] = opnd_b;

   for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
      fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .op  (ops[gi]),
         .cls (cls[gi])
      );
   end

   fcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
      .a      (opnd_a),
      .b      (opnd_b),
      .a_lt_b (a_lt_b),
      .b_lt_a (b_lt_a),
      .a_eq_b (a_eq_b)
   );

   fcmp_select u_sel (
      .cond    (cond_e),
      .cls_a   (cls[0]),
      .cls_b   (cls[1]),
      .a_lt_b  (a_lt_b),
      .b_lt_a  (b_lt_a),
      .a_eq_b  (a_eq_b),
      .raw_res (raw_res),
      .raw_inv (raw_inv)
   );

   fcmp_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (cmp_valid),
      .raw_inv   (raw_inv),
      .clr       (inv_clr),
      .cfg_en    (cfg_fpexc_en),
      .glb_en    (glb_exc_en),
      .sticky    (inv_sticky),
      .exc_pulse (exc_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_bit   <= 1'b0;
      end else begin
         res_valid <= cmp_valid;
         res_bit   <= cmp_valid & raw_res;
      end
   end

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> res_valid);
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> !res_valid && !res_bit);
   p_unord_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && cond_e == CC_UNORD && (cls[0].nan || cls[1].nan) |=> res_bit);
   p_nlt_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && cond_e == CC_NLT && (cls[0].nan || cls[1].nan) |=> res_bit && inv_sticky);
   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && cond_e == CC_RSVD |=> !res_bit);
   p_signed_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && cond_e == CC_EQ && cls[0].zero && cls[1].zero |=> res_bit);
   p_exc_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> res_valid);
endmodule

// File: tb/fcmp_unit_bench.sv
`timescale 1ns/1ps
module fcmp_unit_bench;
   localparam int EW = 3;
   localparam int MW = 2;
   localparam int W  = 1 + EW + MW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmp_valid = 1'b0;
   logic [2:0]   cmp_cond = 3'd0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic         cfg_fpexc_en = 1'b0;
   logic         glb_exc_en = 1'b0;
   logic         inv_clr = 1'b0;
   logic         res_valid, res_bit, inv_sticky, exc_req;

   int  n_vec  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;
   bit  m_flag = 1'b0;

   always #2 clk = ~clk;

   fcmp_unit #(.EXP_W(EW), .MAN_W(MW)) u_fcmp_unit (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .cfg_fpexc_en(cfg_fpexc_en),
      .glb_exc_en(glb_exc_en), .inv_clr(inv_clr), .res_valid(res_valid),
      .res_bit(res_bit), .inv_sticky(inv_sticky), .exc_req(exc_req)
   );

   function automatic bit m_nan(input logic [W-1:0] x);
      return (x[W-2:MW] == '1) && (x[MW-1:0] != '0);
   endfunction
   function automatic bit m_snan(input logic [W-1:0] x);
      return m_nan(x) && !x[MW-1];
   endfunction
   function automatic int m_key(input logic [W-1:0] x);
      int mag;
      mag = int'(x[W-2:0]);
      return x[W-1] ? -mag : mag;
   endfunction

   function automatic string cond_tag(input int c);
      case (c)
         0: return "R1";
         1, 3, 4: return "R3";
         2, 5: return "R4";
         6: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0b expected %0b (cond %0d a %h b %h)",
                  tag, what, got, exp, cmp_cond, opnd_a, opnd_b);
      end
   endtask

   // Called at a falling edge; drives one request and checks it at the next falling edge.
   task automatic apply(input bit v, input int c, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit cfg, input bit glb, input bit clr, input string tag);
      bit anyn, anys, r, inv, ka_lt_kb, kb_lt_ka, keq;
      cmp_valid = v; cmp_cond = 3'(c); opnd_a = a; opnd_b = b;
      cfg_fpexc_en = cfg; glb_exc_en = glb; inv_clr = clr;
      anyn = m_nan(a) || m_nan(b);
      anys = m_snan(a) || m_snan(b);
      ka_lt_kb = m_key(a) < m_key(b);
      kb_lt_ka = m_key(b) < m_key(a);
      keq = m_key(a) == m_key(b);
      case (c)
         0: begin r = anyn;                    inv = anys; end
         1: begin r = !anyn && kb_lt_ka;       inv = anyn; end
         2: begin r = !anyn && keq;            inv = anys; end
         3: begin r = !anyn && !kb_lt_ka;      inv = anyn; end
         4: begin r = !anyn && ka_lt_kb;       inv = anyn; end
         5: begin r = anyn || !keq;            inv = anys; end
         6: begin r = anyn || !ka_lt_kb;       inv = anyn; end
         default: begin r = 1'b0;              inv = 1'b0; end
      endcase
      if (!v) begin r = 1'b0; inv = 1'b0; end
      m_flag = (m_flag && !clr) || inv;
      @(negedge clk);
      n_vec++;
      chk("R9", "res_valid", res_valid, v);
      chk(tag, "res_bit", res_bit, r);
      chk("R10", "inv_sticky", inv_sticky, m_flag);
      chk("R11", "exc_req", exc_req, inv && cfg && glb);
   endtask

   localparam logic [W-1:0] P_ZERO = 6'b000000;
   localparam logic [W-1:0] N_ZERO = 6'b100000;
   localparam logic [W-1:0] P_INF  = 6'b011100;
   localparam logic [W-1:0] Q_NAN  = 6'b011110;
   localparam logic [W-1:0] S_NAN  = 6'b011101;
   localparam logic [W-1:0] P_ONE  = 6'b001100;

   initial begin
      int n;
      repeat (3) @(negedge clk);
      n_vec++;
      chk("R12", "res_valid", res_valid, 1'b0);
      chk("R12", "res_bit", res_bit, 1'b0);
      chk("R12", "inv_sticky", inv_sticky, 1'b0);
      chk("R12", "exc_req", exc_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      n = 0;
      for (int c = 0; c < 8; c++)
         for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++) begin
               apply(1'b1, c, 6'(a), 6'(b), n[2], n[4] ^ n[0], (n % 11) == 0, cond_tag(c));
               n++;
            end

      // Directed corners
      apply(1'b1, 2, P_ZERO, P_ZERO, 1'b0, 1'b0, 1'b1, "R4");
      apply(1'b1, 2, P_ZERO, N_ZERO, 1'b0, 1'b0, 1'b0, "R6");   // R6: +0 equals -0
      apply(1'b1, 4, N_ZERO, P_ZERO, 1'b0, 1'b0, 1'b0, "R6");
      apply(1'b1, 0, P_INF, P_INF, 1'b1, 1'b1, 1'b0, "R7");     // R7: infinity is ordered
      apply(1'b1, 2, P_INF, P_INF, 1'b1, 1'b1, 1'b0, "R7");
      apply(1'b1, 0, Q_NAN, P_ONE, 1'b1, 1'b1, 1'b0, "R2");     // R2: quiet NaN, no invalid
      apply(1'b1, 0, P_ONE, S_NAN, 1'b1, 1'b1, 1'b0, "R2");     // R2: signaling NaN, invalid + exc
      apply(1'b0, 6, S_NAN, S_NAN, 1'b1, 1'b1, 1'b0, "R9");     // idle: no pulse
      apply(1'b1, 3, Q_NAN, P_ONE, 1'b1, 1'b0, 1'b1, "R10");    // clear and set together
      apply(1'b1, 2, P_ONE, P_ONE, 1'b1, 1'b1, 1'b1, "R10");    // clear alone
      apply(1'b0, 6, Q_NAN, Q_NAN, 1'b1, 1'b1, 1'b0, "R9");     // no request, flag stays low
      apply(1'b1, 6, Q_NAN, P_ONE, 1'b1, 1'b1, 1'b0, "R5");
      apply(1'b1, 7, S_NAN, S_NAN, 1'b1, 1'b1, 1'b1, "R8");
      apply(1'b1, 1, P_ONE, P_ZERO, 1'b0, 1'b1, 1'b0, "R3");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule